// File: doc/BRIEF.md
# Bus-Master Disk DMA Sequencer

This block runs bus-master DMA bursts between a parallel disk device and a memory-side line buffer. A start pulse makes the channel busy and asks for the first descriptor. Each descriptor gives a count of 16-bit words and a flag that marks the last descriptor. The sequencer then drives the device read strobe (device to memory) or the device write strobe (memory to device). It also drives the DMA acknowledge. Strobe high time and recovery time come from one of two programmable timing sets, slow and fast. A DMA-only enable picks the fast set.

The device DMA request is sampled on the clock edge where the strobe falls. If the request is low there, the acknowledge falls one clock later and nothing more happens until the request returns. A status pair holds a busy bit and an interrupt bit. The busy bit clears after the last word of the final descriptor, even when the line buffer still holds data bound for memory. For that reason the block raises a retry flag. While the flag is high, the host side must retry non-memory reads until the buffer is empty.

Top module: `bmdma_seq`

## Requirements
- R1: After reset all outputs are low. A start pulse while idle sets `sts_active` and raises `desc_req` on the next clock. `desc_req` falls once a descriptor is taken with `desc_valid`.
- R2: Each strobe stays high for exactly the selected assert count of clocks. Between back-to-back strobes of one descriptor it stays low for exactly the selected recovery count.
- R3: With `fast_dma_en` = 0 the slow timing pair is used. With `fast_dma_en` = 1 the fast pair is used.
- R4: `to_mem` = 1 at start selects `rd_strobe` and `to_mem` = 0 selects `wr_strobe`. The two strobes are never high together.
- R5: `dmarq` is sampled on the edge where the strobe falls. If it is low there, `dma_ack` is still high in the cycle after that edge and low one clock later. No new strobe begins until `dmarq` is high again.
- R6: `dma_ack` is high during every strobe. It stays high across back-to-back transfers while `dmarq` is high at each sample.
- R7: A descriptor of N words produces exactly N strobes. If its last-descriptor flag is clear, `desc_req` is raised again for the next descriptor.
- R8: `sts_active` clears after the last word of the descriptor whose last-descriptor flag is set.
- R9: `dev_irq` high sets `sts_irq` on the next clock. `irq_clr` clears it, but a set in the same cycle wins.
- R10: Each device-to-memory word adds one to the line-buffer fill and each `lb_drain` pulse removes one. With the buffer holding `LB_DEPTH` words, no new read strobe starts.
- R11: `rd_retry` is high within two clocks whenever the buffer is non-empty and either `sts_active` is clear or `sts_irq` is set. It is low within two clocks once neither holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| to_mem | input | 1 | Direction at start: 1 device-to-memory, 0 memory-to-device |
| fast_dma_en | input | 1 | Use fast timing pair for DMA |
| slow_assert | input | TW | Slow strobe high clocks (at least 1) |
| slow_recov | input | TW | Slow recovery clocks (at least 1) |
| fast_assert | input | TW | Fast strobe high clocks (at least 1) |
| fast_recov | input | TW | Fast recovery clocks (at least 1) |
| desc_req | output | 1 | Next descriptor wanted |
| desc_valid | input | 1 | Descriptor present on desc_words / desc_eot |
| desc_words | input | CW | Word count of the descriptor |
| desc_eot | input | 1 | Last-descriptor flag |
| dmarq | input | 1 | Device DMA request |
| dev_irq | input | 1 | Device interrupt |
| irq_clr | input | 1 | Write-one clear of the interrupt bit |
| lb_drain | input | 1 | One buffered word written to memory |
| rd_strobe | output | 1 | Device read strobe |
| wr_strobe | output | 1 | Device write strobe |
| dma_ack | output | 1 | DMA acknowledge |
| sts_active | output | 1 | Busy status bit |
| sts_irq | output | 1 | Interrupt status bit |
| rd_retry | output | 1 | Retry non-memory host reads |

## Verification
Several request patterns are used.
- A request held high over a single-descriptor read burst shows continuous acknowledge and exact recovery gaps.
- A two-descriptor write burst on the fast timing pair separates the fast and slow sets and checks the descriptor hand-off.
- Dropping the request in the middle of a strobe checks the sample point, the one-clock acknowledge fall and the stall.
- An undrained device-to-memory burst longer than the buffer checks the stall on a full buffer.

The retry flag is exercised through both of its causes. It is checked after the busy bit clears with data still buffered. It is also checked with the busy bit still set and the interrupt bit set. Each case is followed by draining the buffer to show that the flag falls.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_WAIT, SQ_STRB, SQ_RECOV, SQ_END
  } seq_state_t;
endpackage

// File: rtl/bmdma_timing_sel.sv
module bmdma_timing_sel #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fast_en,
  input  logic [TW-1:0] slow_assert,
  input  logic [TW-1:0] slow_recov,
  input  logic [TW-1:0] fast_assert,
  input  logic [TW-1:0] fast_recov,
  output logic [TW-1:0] asrt_q,
  output logic [TW-1:0] recov_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      asrt_q  <= TW'(1);
      recov_q <= TW'(1);
    end else begin
      asrt_q  <= fast_en ? fast_assert : slow_assert;
      recov_q <= fast_en ? fast_recov  : slow_recov;
    end
  end

  p_sel_r3: assert property (@(posedge clk) disable iff (rst)
    fast_en |=> (asrt_q == $past(fast_assert)));
endmodule

// File: rtl/bmdma_lb_count.sv
module bmdma_lb_count #(
  parameter int LB_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fill,
  input  logic drain,
  output logic full,
  output logic nonempty
);
  localparam int LBW = $clog2(LB_DEPTH + 1);
  logic [LBW-1:0] cnt;
  logic do_fill, do_drain;

  assign do_fill  = fill && (cnt != LBW'(LB_DEPTH));
  assign do_drain = drain && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (do_fill && !do_drain) cnt <= cnt + 1'b1;
    else if (do_drain && !do_fill) cnt <= cnt - 1'b1;
  end

  assign full     = (cnt == LBW'(LB_DEPTH));
  assign nonempty = (cnt != '0);

  p_lb_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LBW'(LB_DEPTH));
  p_lb_no_lost_fill_r10: assert property (@(posedge clk) disable iff (rst)
    full |-> !fill);
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status (
  input  logic clk,
  input  logic rst,
  input  logic start_go,
  input  logic done_eot,
  input  logic dev_irq,
  input  logic irq_clr,
  input  logic lb_nonempty,
  output logic sts_active,
  output logic sts_irq,
  output logic rd_retry
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_active <= 1'b0;
      sts_irq    <= 1'b0;
      rd_retry   <= 1'b0;
    end else begin
      if (start_go)      sts_active <= 1'b1;
      else if (done_eot) sts_active <= 1'b0;
      if (dev_irq)       sts_irq <= 1'b1;
      else if (irq_clr)  sts_irq <= 1'b0;
      rd_retry <= lb_nonempty && (!sts_active || sts_irq);
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_go |=> sts_active);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    dev_irq |=> sts_irq);
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !dev_irq) |=> !sts_irq);
  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    (done_eot && !start_go) |=> !sts_active);
endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq #(
  parameter int CW       = 16,
  parameter int TW       = 3,
  parameter int LB_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          to_mem,
  input  logic          fast_dma_en,
  input  logic [TW-1:0] slow_assert,
  input  logic [TW-1:0] slow_recov,
  input  logic [TW-1:0] fast_assert,
  input  logic [TW-1:0] fast_recov,
  output logic          desc_req,
  input  logic          desc_valid,
  input  logic [CW-1:0] desc_words,
  input  logic          desc_eot,
  input  logic          dmarq,
  input  logic          dev_irq,
  input  logic          irq_clr,
  input  logic          lb_drain,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic          dma_ack,
  output logic          sts_active,
  output logic          sts_irq,
  output logic          rd_retry
);
  import bmdma_pkg::*;

  seq_state_t    state;
  logic [TW-1:0] asrt_q, recov_q, tmr;
  logic [CW-1:0] remain;
  logic          eot_q, dir_q, go_on, drop_pend;
  logic          lb_full, lb_nonempty;
  logic          start_go, done_eot, word_done, strb_any;

  assign start_go  = start && (state == SQ_IDLE);
  assign done_eot  = (state == SQ_END) && eot_q;
  assign word_done = (state == SQ_STRB) && (tmr == '0);
  assign strb_any  = rd_strobe || wr_strobe;

  bmdma_timing_sel #(.TW(TW)) u_tsel (
    .clk(clk), .rst(rst), .fast_en(fast_dma_en),
    .slow_assert(slow_assert), .slow_recov(slow_recov),
    .fast_assert(fast_assert), .fast_recov(fast_recov),
    .asrt_q(asrt_q), .recov_q(recov_q)
  );

  bmdma_lb_count #(.LB_DEPTH(LB_DEPTH)) u_lb (
    .clk(clk), .rst(rst), .fill(word_done && dir_q), .drain(lb_drain),
    .full(lb_full), .nonempty(lb_nonempty)
  );

  bmdma_status u_sts (
    .clk(clk), .rst(rst), .start_go(start_go), .done_eot(done_eot),
    .dev_irq(dev_irq), .irq_clr(irq_clr), .lb_nonempty(lb_nonempty),
    .sts_active(sts_active), .sts_irq(sts_irq), .rd_retry(rd_retry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      desc_req  <= 1'b0;
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      dma_ack   <= 1'b0;
      tmr       <= '0;
      remain    <= '0;
      eot_q     <= 1'b0;
      dir_q     <= 1'b0;
      go_on     <= 1'b0;
      drop_pend <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          dir_q    <= to_mem;
          desc_req <= 1'b1;
          state    <= SQ_FETCH;
        end
        SQ_FETCH: if (desc_valid) begin
          remain   <= desc_words;
          eot_q    <= desc_eot;
          desc_req <= 1'b0;
          state    <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (remain == '0) begin
            state <= SQ_END;
          end else if (dmarq && !(dir_q && lb_full)) begin
            dma_ack   <= 1'b1;
            rd_strobe <= dir_q;
            wr_strobe <= !dir_q;
            tmr       <= asrt_q - TW'(1);
            state     <= SQ_STRB;
          end
        end
        SQ_STRB: begin
          if (tmr == '0) begin
            rd_strobe <= 1'b0;
            wr_strobe <= 1'b0;
            remain    <= remain - CW'(1);
            go_on     <= dmarq && (remain != CW'(1));
            drop_pend <= !dmarq || (remain == CW'(1));
            tmr       <= recov_q - TW'(1);
            state     <= SQ_RECOV;
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        SQ_RECOV: begin
          if (drop_pend) begin
            dma_ack   <= 1'b0;
            drop_pend <= 1'b0;
          end
          if (tmr == '0) begin
            if (remain == '0) begin
              state <= SQ_END;
            end else if (go_on && !(dir_q && lb_full)) begin
              rd_strobe <= dir_q;
              wr_strobe <= !dir_q;
              tmr       <= asrt_q - TW'(1);
              state     <= SQ_STRB;
            end else begin
              state <= SQ_WAIT;
            end
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        SQ_END: begin
          if (eot_q) begin
            state <= SQ_IDLE;
          end else begin
            desc_req <= 1'b1;
            state    <= SQ_FETCH;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));
  p_ack_cover_r6: assert property (@(posedge clk) disable iff (rst)
    strb_any |-> dma_ack);
  p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(strb_any) && !$past(dmarq)) |=> !dma_ack);
  p_no_strobe_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !sts_active |-> !strb_any);
  p_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe) |-> !$past(lb_full));
endmodule

// File: tb/test_bmdma_seq.sv
`timescale 1ns/1ps
module test_bmdma_seq;
  localparam int CW = 16, TW = 3, LB_DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, to_mem = 0, fast_dma_en = 0;
  logic [TW-1:0] slow_assert = 3, slow_recov = 2, fast_assert = 2, fast_recov = 1;
  logic desc_req, desc_valid = 0, desc_eot = 0;
  logic [CW-1:0] desc_words = 0;
  logic dmarq = 0, dev_irq = 0, irq_clr = 0, lb_drain = 0;
  logic rd_strobe, wr_strobe, dma_ack, sts_active, sts_irq, rd_retry;

  always #2 clk = ~clk;

  bmdma_seq #(.CW(CW), .TW(TW), .LB_DEPTH(LB_DEPTH)) i_bmdma_seq (
    .clk(clk), .rst(rst), .start(start), .to_mem(to_mem), .fast_dma_en(fast_dma_en),
    .slow_assert(slow_assert), .slow_recov(slow_recov),
    .fast_assert(fast_assert), .fast_recov(fast_recov),
    .desc_req(desc_req), .desc_valid(desc_valid), .desc_words(desc_words),
    .desc_eot(desc_eot), .dmarq(dmarq), .dev_irq(dev_irq), .irq_clr(irq_clr),
    .lb_drain(lb_drain), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .dma_ack(dma_ack), .sts_active(sts_active), .sts_irq(sts_irq), .rd_retry(rd_retry)
  );

  int errors = 0, checks = 0;
  int n_rd = 0, n_wr = 0, n_dreq = 0, hi_run = 0, lo_run = 0;
  int exp_assert = 3, exp_recov = 2;
  bit chk_gap = 0, mon_on = 0, drop_chk = 0, prev_strb = 0, prev_dreq = 0;
  bit seen_strobe = 0;
  logic dmarq_edge = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) dmarq_edge <= dmarq;

  always @(negedge clk) begin
    bit s;
    s = rd_strobe | wr_strobe;
    if (mon_on) begin
      if (drop_chk) begin
        chk(dma_ack == 0, "R5 ack drop one clock after strobe fall", dma_ack, 0);
        drop_chk = 0;
      end
      if (rd_strobe && wr_strobe) chk(0, "R4 both strobes high", 1, 0);
      if (s) chk(dma_ack == 1, "R6 ack high during strobe", dma_ack, 1);
      if (desc_req && !prev_dreq) n_dreq++;
      if (s && !prev_strb) begin
        n_rd += rd_strobe; n_wr += wr_strobe;
        if (chk_gap && seen_strobe)
          chk(lo_run == exp_recov, "R2 recovery width", lo_run, exp_recov);
        seen_strobe = 1;
        hi_run = 1;
      end else if (s) hi_run++;
      if (!s && prev_strb) begin
        chk(hi_run == exp_assert, "R2/R3 strobe width", hi_run, exp_assert);
        lo_run = 1;
        if (!dmarq_edge) begin
          chk(dma_ack == 1, "R5 ack still high at strobe fall", dma_ack, 1);
          drop_chk = 1;
        end
      end else if (!s) lo_run++;
    end
    prev_strb = s;
    prev_dreq = desc_req;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mon_reset(input int a, input int r, input bit gap);
    n_rd = 0; n_wr = 0; n_dreq = 0; exp_assert = a; exp_recov = r;
    chk_gap = gap; seen_strobe = 0; mon_on = 1;
  endtask

  task automatic pulse_start(input bit dir);
    @(negedge clk); to_mem = dir; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic serve_desc(input int words, input bit eot);
    int t = 0;
    while (!desc_req && t < 500) begin @(negedge clk); t++; end
    chk(desc_req == 1, "R1/R7 descriptor request raised", desc_req, 1);
    desc_valid = 1; desc_words = CW'(words); desc_eot = eot;
    @(negedge clk); desc_valid = 0;
    chk(desc_req == 0, "R1 request falls after descriptor taken", desc_req, 0);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (sts_active && t < 2000) begin @(negedge clk); t++; end
    chk(sts_active == 0, "R8 active clears after last descriptor", sts_active, 0);
  endtask

  task automatic drain(input int n);
    repeat (n) begin
      @(negedge clk); lb_drain = 1;
      @(negedge clk); lb_drain = 0;
    end
  endtask

  task automatic t_reset();
    cyc(3); rst = 0; cyc(1);
    chk({desc_req, rd_strobe, wr_strobe, dma_ack, sts_active, sts_irq, rd_retry} == 0,
        "R1 reset outputs low", {desc_req, rd_strobe, wr_strobe, dma_ack, sts_active, sts_irq, rd_retry}, 0);
  endtask

  // Slow timing, device-to-memory, request held high, no drain
  task automatic t_slow_read();
    fast_dma_en = 0; slow_assert = 3; slow_recov = 2; dmarq = 1;
    cyc(2); mon_reset(3, 2, 1);
    pulse_start(1);
    chk(sts_active == 1, "R1 active set by start", sts_active, 1);
    serve_desc(3, 1);
    wait_idle();
    chk(n_rd == 3, "R7 strobe count one descriptor", n_rd, 3);
    chk(n_wr == 0, "R4 read direction no write strobe", n_wr, 0);
    cyc(2);
    chk(rd_retry == 1, "R11 retry after active clear with data", rd_retry, 1);
    drain(3); cyc(2);
    chk(rd_retry == 0, "R11 retry falls when buffer empty", rd_retry, 0);
  endtask

  // Fast timing, memory-to-device, two descriptors
  task automatic t_fast_write();
    fast_dma_en = 1; fast_assert = 2; fast_recov = 1; dmarq = 1;
    cyc(2); mon_reset(2, 1, 0);
    pulse_start(0);
    serve_desc(2, 0);
    serve_desc(1, 1);
    wait_idle();
    chk(n_wr == 3, "R7 strobe count two descriptors", n_wr, 3);
    chk(n_rd == 0, "R4 write direction no read strobe", n_rd, 0);
    chk(n_dreq == 2, "R7 second descriptor requested", n_dreq, 2);
    cyc(2);
    chk(rd_retry == 0, "R11 no retry with empty buffer", rd_retry, 0);
    fast_dma_en = 0;
  endtask

  // Request dropped during a strobe
  task automatic t_req_drop();
    int t = 0;
    fast_dma_en = 0; slow_assert = 3; slow_recov = 2; dmarq = 1;
    cyc(2); mon_reset(3, 2, 0);
    pulse_start(0);
    serve_desc(4, 1);
    while (!wr_strobe && t < 100) begin @(negedge clk); t++; end
    dmarq = 0;
    cyc(12);
    chk(n_wr == 1, "R5 no new strobe while request low", n_wr, 1);
    chk(dma_ack == 0, "R5 ack stays low while request low", dma_ack, 0);
    dmarq = 1;
    wait_idle();
    chk(n_wr == 4, "R5 transfers resume after request returns", n_wr, 4);
  endtask

  // Buffer full stall
  task automatic t_full();
    slow_assert = 2; slow_recov = 1; dmarq = 1;
    cyc(2); mon_reset(2, 1, 0);
    pulse_start(1);
    serve_desc(6, 1);
    cyc(40);
    chk(n_rd == LB_DEPTH, "R10 stall when buffer full", n_rd, LB_DEPTH);
    chk(sts_active == 1, "R10 still active while stalled", sts_active, 1);
    chk(rd_retry == 0, "R11 no retry while active and no irq", rd_retry, 0);
    drain(2); cyc(8);
    wait_idle();
    chk(n_rd == 6, "R10 resumes after drain", n_rd, 6);
    cyc(2);
    chk(rd_retry == 1, "R11 retry with buffer still full", rd_retry, 1);
    drain(4); cyc(2);
    chk(rd_retry == 0, "R11 retry falls after drain", rd_retry, 0);
  endtask

  // Interrupt status and retry through the interrupt path
  task automatic t_irq();
    int t = 0;
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    chk(sts_irq == 1, "R9 interrupt sets status", sts_irq, 1);
    cyc(2);
    chk(rd_retry == 0, "R11 no retry when buffer empty", rd_retry, 0);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(sts_irq == 0, "R9 clear by write-one", sts_irq, 0);
    @(negedge clk); irq_clr = 1; dev_irq = 1; @(negedge clk); irq_clr = 0; dev_irq = 0;
    chk(sts_irq == 1, "R9 set wins over clear", sts_irq, 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    slow_assert = 2; slow_recov = 1; dmarq = 1;
    cyc(2); mon_reset(2, 1, 0);
    pulse_start(1);
    serve_desc(2, 1);
    while (!rd_strobe && t < 100) begin @(negedge clk); t++; end
    dmarq = 0;
    cyc(8);
    chk(sts_active == 1 && rd_retry == 0, "R11 no retry while active without irq", rd_retry, 0);
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    cyc(2);
    chk(rd_retry == 1, "R11 retry on irq with data buffered", rd_retry, 1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    cyc(2);
    chk(rd_retry == 0, "R11 retry falls after irq clear while active", rd_retry, 0);
    dmarq = 1;
    wait_idle();
    chk(n_rd == 2, "R7 strobe count after stall", n_rd, 2);
    drain(2); cyc(2);
    chk(rd_retry == 0, "R11 retry falls after final drain", rd_retry, 0);
  endtask

  initial begin
    t_reset();
    t_slow_read();
    t_fast_write();
    t_req_drop();
    t_full();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule